// File: doc/BRIEF.md
# Horizontally Microcoded Stack Processor Core

This block is a small stack-oriented processor core with no fixed opcode set. Every instruction is a wide word made of independent operation fields, one per internal component: program counter, top-of-stack register, data stack, return stack, function unit and memory port. All of these fields act in the same clock cycle. A short run of such words forms a reusable routine, for example "store the top value to an output address and restore the stack".

Program words come from an external code port whose address is the next program counter. The word is captured into the instruction register on each clock edge, so a new word executes every cycle with no bubble, even after a branch. Data accesses use the top register as the address. The address space is split into a read-only ROM window, an internal RAM and an external I/O window that reaches the control registers of outside units. The function unit has only logic and shift operations. Arithmetic is built in microcode from sequences of these operations.

Top module: `hsp_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter goes to 0, the top register (`tr_out`) goes to 0, both stacks become empty and both error flags clear. `code_addr` is 0 while `rst` is high.
- R2: The instruction word is laid out MSB first as follows: pc_op[3], nxt[2], tr_op[3], ds_op[2], rs_op[2], fu_op[3], mem_op[2], target[ADDR_W], imm[DATA_W]. All fields take effect in the same cycle. tr_op codes: 0 hold, 1 load imm, 2 load function unit result, 3 load memory read data, 4 load data stack head.
- R3: With pc_op 0 (sequential), nxt selects the next address: 0 gives +0, which holds the same word; 1 gives +1; 2 gives +2, which skips one word; 3 gives +1.
- R4: pc_op 1 jumps to target. pc_op 2 jumps to target only if the top register is zero, and pc_op 3 only if it is non-zero. A branch that is not taken follows nxt.
- R5: rs_op 1 pushes PC+1 onto the return stack. rs_op 2 pops it. pc_op 4 loads the PC from the return stack head. pc_op 1 with rs_op 1 is a call; pc_op 4 with rs_op 2 is a return. Calls nest in last-in, first-out order.
- R6: ds_op 1 pushes the old top register onto the data stack. ds_op 2 pops the data stack. Values come back in last-in, first-out order.
- R7: fu_op codes, where A is the top register and B is the data stack head: 0 A, 1 A&B, 2 A|B, 3 A^B, 4 ~A, 5 A shifted left by one, 6 A shifted right by one, 7 B.
- R8: Memory access uses the top register as the address. The two address MSBs select the region: 00 ROM, 01 RAM, 1x external I/O. mem_op 1 reads. mem_op 2 writes the data stack head. A RAM write is read back by a later read of the same address.
- R9: A write to the I/O window drives `eio_we` with `eio_addr` set to the address minus its MSB and `eio_wdata` set to the stack head. A read of the I/O window drives `eio_re` and returns `eio_rdata`.
- R10: A read of the ROM window returns `rom_rdata` for `rom_addr` = the address minus its two MSBs. A write to the ROM window changes neither RAM nor the I/O port.
- R11: A push onto a full stack or a pop from an empty stack sets that stack's sticky error flag (`ds_err` or `rs_err`) and leaves the stack contents and depth unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_addr | output | ADDR_W | Address of the next program word |
| code_rdata | input | 17+ADDR_W+DATA_W | Program word at `code_addr` (combinational read) |
| rom_addr | output | ADDR_W-2 | Offset of a data read in the ROM window |
| rom_rdata | input | DATA_W | ROM data at `rom_addr` |
| eio_addr | output | ADDR_W-1 | Offset within the external I/O window |
| eio_wdata | output | DATA_W | External I/O write data |
| eio_we | output | 1 | External I/O write strobe |
| eio_re | output | 1 | External I/O read strobe |
| eio_rdata | input | DATA_W | External I/O read data |
| tr_out | output | DATA_W | Current top-of-stack register |
| ds_err | output | 1 | Sticky data stack overflow/underflow flag |
| rs_err | output | 1 | Sticky return stack overflow/underflow flag |

## Verification
A single microprogram is run. It brings every intermediate result out through I/O window writes, which a scoreboard compares in order together with the two error flags. The function unit is driven with operand pairs whose bits differ, so that every one of the eight operations gives a distinct value. Branches are exercised both taken and not taken, and a taken branch lands on code that outputs a different value from the skipped words. A misdirected branch lands on an idle word and starves the scoreboard. A ROM-window write is aimed at the RAM alias of a known RAM word, so that a region decode fault shows up as a changed read-back. Nested calls, a stack underflow followed by a push and pop, and a return stack overflow show LIFO order and that a fault leaves the stack contents intact.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    typedef enum logic [2:0] {
        PC_SEQ = 3'd0,
        PC_JMP = 3'd1,
        PC_JZ  = 3'd2,
        PC_JNZ = 3'd3,
        PC_RET = 3'd4
    } pc_op_e;

    typedef enum logic [1:0] {
        NXT_STAY = 2'd0,
        NXT_ONE  = 2'd1,
        NXT_TWO  = 2'd2,
        NXT_ALT  = 2'd3
    } nxt_e;

    typedef enum logic [2:0] {
        TR_HOLD = 3'd0,
        TR_IMM  = 3'd1,
        TR_FU   = 3'd2,
        TR_MEM  = 3'd3,
        TR_DSH  = 3'd4
    } tr_op_e;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    typedef enum logic [2:0] {
        FU_A    = 3'd0,
        FU_AND  = 3'd1,
        FU_OR   = 3'd2,
        FU_XOR  = 3'd3,
        FU_NOT  = 3'd4,
        FU_SHL  = 3'd5,
        FU_SHR  = 3'd6,
        FU_B    = 3'd7
    } fu_op_e;

    typedef enum logic [1:0] {
        MEM_NONE = 2'd0,
        MEM_RD   = 2'd1,
        MEM_WR   = 2'd2
    } mem_op_e;

    typedef enum logic [1:0] {
        RG_ROM = 2'd0,
        RG_RAM = 2'd1,
        RG_EIO = 2'd2
    } region_e;

    // Control part of an instruction word, most significant field first.
    typedef struct packed {
        pc_op_e  pc;
        nxt_e    nxt;
        tr_op_e  tr;
        stk_op_e ds;
        stk_op_e rs;
        fu_op_e  fu;
        mem_op_e mem;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic region_e region_of(input logic [1:0] msbs);
        case (msbs)
            2'b00:   return RG_ROM;
            2'b01:   return RG_RAM;
            default: return RG_EIO;
        endcase
    endfunction

    function automatic logic [1:0] seq_step(input nxt_e n);
        case (n)
            NXT_STAY: return 2'd0;
            NXT_TWO:  return 2'd2;
            default:  return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/hsp_stack.sv
module hsp_stack #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         err
);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  slot [DEPTH];
    logic          full, empty, do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !push && !empty;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && cnt_q == CW'(i)) begin
                slot[i] <= din;
            end
        end
    end

    assign head = empty ? '0 : slot[IDX_W'(cnt_q - 1'b1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            err   <= 1'b0;
        end else begin
            if (do_push) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (do_pop) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if ((push && full) || (pop && !push && empty)) begin
                err <= 1'b1;
            end
        end
    end

    p_ovf_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> (cnt_q == $past(cnt_q)));
    p_unf_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> (cnt_q == '0));
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    p_depth_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));
    p_push_head_r6: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> (head == $past(din)));
endmodule

// File: rtl/hsp_fu.sv
module hsp_fu
    import hsp_pkg::*;
#(
    parameter int W = 8
) (
    input  fu_op_e       op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            FU_AND:  y = a & b;
            FU_OR:   y = a | b;
            FU_XOR:  y = a ^ b;
            FU_NOT:  y = ~a;
            FU_SHL:  y = a << 1;
            FU_SHR:  y = a >> 1;
            FU_B:    y = b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/hsp_memmap.sv
module hsp_memmap
    import hsp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  mem_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-3:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [ADDR_W-2:0] eio_addr,
    output logic [DATA_W-1:0] eio_wdata,
    output logic              eio_we,
    output logic              eio_re,
    input  logic [DATA_W-1:0] eio_rdata
);
    localparam int RAM_AW    = ADDR_W - 2;
    localparam int RAM_DEPTH = 1 << RAM_AW;

    logic [DATA_W-1:0] ram [RAM_DEPTH];
    region_e           rg;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_idx;

    assign rg        = region_of(addr[ADDR_W-1 -: 2]);
    assign ram_idx   = addr[RAM_AW-1:0];
    assign ram_we    = (op == MEM_WR) && (rg == RG_RAM);
    assign eio_we    = (op == MEM_WR) && (rg == RG_EIO);
    assign eio_re    = (op == MEM_RD) && (rg == RG_EIO);
    assign eio_addr  = addr[ADDR_W-2:0];
    assign eio_wdata = wdata;
    assign rom_addr  = addr[ADDR_W-3:0];

    always_ff @(posedge clk) begin
        if (ram_we) begin
            ram[ram_idx] <= wdata;
        end
    end

    always_comb begin
        case (rg)
            RG_ROM:  rdata = rom_rdata;
            RG_RAM:  rdata = ram[ram_idx];
            default: rdata = eio_rdata;
        endcase
    end

    p_ram_rdback_r8: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> ((op != MEM_RD) || (addr != $past(addr)) || (rdata == $past(wdata))));
    p_eio_window_r9: assert property (@(posedge clk) disable iff (rst)
        (eio_we || eio_re) |-> addr[ADDR_W-1]);
    p_rom_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (op == MEM_WR && addr[ADDR_W-1 -: 2] == 2'b00) |-> !eio_we);
endmodule

// File: rtl/hsp_core.sv
module hsp_core
    import hsp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 8,
    parameter int DS_DEPTH = 4,
    parameter int RS_DEPTH = 4,
    localparam int IW      = CTRL_W + ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] code_addr,
    input  logic [IW-1:0]     code_rdata,
    output logic [ADDR_W-3:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [ADDR_W-2:0] eio_addr,
    output logic [DATA_W-1:0] eio_wdata,
    output logic              eio_we,
    output logic              eio_re,
    input  logic [DATA_W-1:0] eio_rdata,
    output logic [DATA_W-1:0] tr_out,
    output logic              ds_err,
    output logic              rs_err
);
    logic [ADDR_W-1:0] pc_q, pc_next, pc_seq, target, rs_head;
    logic [IW-1:0]     ir_q;
    logic [DATA_W-1:0] tr_q, imm, ds_head, fu_y, mem_rdata;
    ctrl_t             ctrl;
    logic              tr_zero;

    // Field extraction from the instruction register
    assign ctrl    = ctrl_t'(ir_q[IW-1 -: CTRL_W]);
    assign target  = ir_q[DATA_W +: ADDR_W];
    assign imm     = ir_q[DATA_W-1:0];
    assign tr_zero = (tr_q == '0);

    // Sequencer
    assign pc_seq = pc_q + ADDR_W'(seq_step(ctrl.nxt));

    always_comb begin
        if (rst) begin
            pc_next = '0;
        end else begin
            case (ctrl.pc)
                PC_JMP:  pc_next = target;
                PC_JZ:   pc_next = tr_zero ? target : pc_seq;
                PC_JNZ:  pc_next = tr_zero ? pc_seq : target;
                PC_RET:  pc_next = rs_head;
                default: pc_next = pc_seq;
            endcase
        end
    end

    assign code_addr = pc_next;

    // Return stack
    hsp_stack #(.W(ADDR_W), .DEPTH(RS_DEPTH)) u_rs (
        .clk  (clk),
        .rst  (rst),
        .push (ctrl.rs == STK_PUSH),
        .pop  (ctrl.rs == STK_POP),
        .din  (pc_q + 1'b1),
        .head (rs_head),
        .err  (rs_err)
    );

    // Data stack
    hsp_stack #(.W(DATA_W), .DEPTH(DS_DEPTH)) u_ds (
        .clk  (clk),
        .rst  (rst),
        .push (ctrl.ds == STK_PUSH),
        .pop  (ctrl.ds == STK_POP),
        .din  (tr_q),
        .head (ds_head),
        .err  (ds_err)
    );

    // Function unit
    hsp_fu #(.W(DATA_W)) u_fu (
        .op (ctrl.fu),
        .a  (tr_q),
        .b  (ds_head),
        .y  (fu_y)
    );

    // Memory port with region decode
    hsp_memmap #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .op        (ctrl.mem),
        .addr      (ADDR_W'(tr_q)),
        .wdata     (ds_head),
        .rdata     (mem_rdata),
        .rom_addr  (rom_addr),
        .rom_rdata (rom_rdata),
        .eio_addr  (eio_addr),
        .eio_wdata (eio_wdata),
        .eio_we    (eio_we),
        .eio_re    (eio_re),
        .eio_rdata (eio_rdata)
    );

    // Program counter, instruction register, top register
    always_ff @(posedge clk) begin
        ir_q <= code_rdata;
        if (rst) begin
            pc_q <= '0;
            tr_q <= '0;
        end else begin
            pc_q <= pc_next;
            case (ctrl.tr)
                TR_IMM:  tr_q <= imm;
                TR_FU:   tr_q <= fu_y;
                TR_MEM:  tr_q <= mem_rdata;
                TR_DSH:  tr_q <= ds_head;
                default: tr_q <= tr_q;
            endcase
        end
    end

    assign tr_out = tr_q;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && tr_q == '0));
    p_imm_load_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl.tr == TR_IMM) |=> (tr_q == $past(imm)));
    p_seq_skip_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pc == PC_SEQ && ctrl.nxt == NXT_TWO) |=> (pc_q == ADDR_W'($past(pc_q) + 2'd2)));
    p_seq_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pc == PC_SEQ && ctrl.nxt == NXT_STAY) |=> $stable(pc_q));
    p_jz_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pc == PC_JZ && tr_zero) |=> (pc_q == $past(target)));
    p_jnz_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pc == PC_JNZ && tr_zero && ctrl.nxt == NXT_ONE) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));
endmodule

// File: tb/hsp_core_bench.sv
`timescale 1ns/1ps
module hsp_core_bench;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int IW     = 17 + ADDR_W + DATA_W;

    // Encodings taken from the requirements
    localparam int SEQ = 0, JMP = 1, JZ = 2, JNZ = 3, RET = 4;
    localparam int T_HOLD = 0, T_IMM = 1, T_FU = 2, T_MEM = 3, T_DS = 4;
    localparam int S_HOLD = 0, S_PUSH = 1, S_POP = 2;
    localparam int F_A = 0, F_AND = 1, F_OR = 2, F_XOR = 3, F_NOT = 4, F_SHL = 5, F_SHR = 6, F_B = 7;
    localparam int M_NONE = 0, M_RD = 1, M_WR = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] code_addr;
    logic [IW-1:0]     code_rdata;
    logic [ADDR_W-3:0] rom_addr;
    logic [DATA_W-1:0] rom_rdata;
    logic [ADDR_W-2:0] eio_addr;
    logic [DATA_W-1:0] eio_wdata;
    logic              eio_we, eio_re;
    logic [DATA_W-1:0] eio_rdata;
    logic [DATA_W-1:0] tr_out;
    logic              ds_err, rs_err;

    logic [IW-1:0] prog [256];

    typedef struct {
        logic [ADDR_W-2:0] a;
        logic [DATA_W-1:0] d;
        logic              dse;
        logic              rse;
        string             req;
    } item_t;

    item_t exp_q[$];
    int    nvec = 0;
    int    nerr = 0;
    int    p    = 0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    assign code_rdata = prog[code_addr];
    assign rom_rdata  = DATA_W'(rom_addr) ^ 8'hA5;
    assign eio_rdata  = DATA_W'(eio_addr) + 8'h01;

    hsp_core u_hsp_core (
        .clk        (clk),
        .rst        (rst),
        .code_addr  (code_addr),
        .code_rdata (code_rdata),
        .rom_addr   (rom_addr),
        .rom_rdata  (rom_rdata),
        .eio_addr   (eio_addr),
        .eio_wdata  (eio_wdata),
        .eio_we     (eio_we),
        .eio_re     (eio_re),
        .eio_rdata  (eio_rdata),
        .tr_out     (tr_out),
        .ds_err     (ds_err),
        .rs_err     (rs_err)
    );

    function automatic logic [IW-1:0] mkw(int pc, int nx, int tr, int ds, int rs,
                                          int fu, int mem, int tgt, int imm);
        return {3'(pc), 2'(nx), 3'(tr), 2'(ds), 2'(rs), 3'(fu), 2'(mem),
                ADDR_W'(tgt), DATA_W'(imm)};
    endfunction

    task automatic put(input logic [IW-1:0] w);
        prog[p] = w;
        p++;
    endtask

    task automatic lit(input int v, input int ds);
        put(mkw(SEQ, 1, T_IMM, ds, S_HOLD, F_A, M_NONE, 0, v));
    endtask

    task automatic fu(input int op, input int ds);
        put(mkw(SEQ, 1, T_FU, ds, S_HOLD, op, M_NONE, 0, 0));
    endtask

    task automatic popw();
        put(mkw(SEQ, 1, T_DS, S_POP, S_HOLD, F_A, M_NONE, 0, 0));
    endtask

    // Two-word routine: write the top register to I/O address a, then restore it.
    task automatic out(input int a, input int v, input bit dse, input bit rse, input string req);
        item_t it;
        lit(a, S_PUSH);
        put(mkw(SEQ, 1, T_DS, S_POP, S_HOLD, F_A, M_WR, 0, 0));
        it.a   = (ADDR_W-1)'(a - 8'h80);
        it.d   = DATA_W'(v);
        it.dse = dse;
        it.rse = rse;
        it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic check(input int act, input int expv, input string req);
        nvec++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Scoreboard monitor: compares each I/O write with the next expected item.
    always @(negedge clk) begin
        if (!rst && eio_we) begin
            if (exp_q.size() == 0) begin
                nvec++;
                nerr++;
                $display("FAIL R9: actual unexpected write %0h@%0h expected none", eio_wdata, eio_addr);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                nvec++;
                if (eio_addr != it.a || eio_wdata != it.d || ds_err != it.dse || rs_err != it.rse) begin
                    nerr++;
                    $display("FAIL %s: actual %0h@%0h err %0b%0b expected %0h@%0h err %0b%0b",
                             it.req, eio_wdata, eio_addr, ds_err, rs_err,
                             it.d, it.a, it.dse, it.rse);
                end
            end
        end
    end

    task automatic assemble();
        int save;
        for (int i = 0; i < 256; i++) prog[i] = '0;
        p = 0;
        // R2: immediate load and output
        lit(8'h5A, S_HOLD);
        out(8'h80, 8'h5A, 0, 0, "R2");
        // R2/R7: push, AND and pop in one word
        lit(8'h0F, S_PUSH);
        fu(F_AND, S_POP);
        out(8'h81, 8'h0A, 0, 0, "R7");
        lit(8'h33, S_PUSH);
        fu(F_OR, S_HOLD);
        out(8'h82, 8'h3B, 0, 0, "R7");
        fu(F_XOR, S_HOLD);
        out(8'h83, 8'h31, 0, 0, "R7");
        fu(F_NOT, S_HOLD);
        out(8'h84, 8'hCE, 0, 0, "R7");
        fu(F_SHL, S_HOLD);
        out(8'h85, 8'h9C, 0, 0, "R7");
        fu(F_SHR, S_HOLD);
        out(8'h86, 8'h4E, 0, 0, "R7");
        fu(F_B, S_HOLD);
        out(8'h87, 8'h0A, 0, 0, "R7");
        popw();
        // R6: LIFO order
        lit(8'h11, S_HOLD);
        lit(8'h22, S_PUSH);
        lit(8'h33, S_PUSH);
        popw();
        out(8'h89, 8'h22, 0, 0, "R6");
        popw();
        out(8'h8A, 8'h11, 0, 0, "R6");
        // R3: skip one word
        put(mkw(SEQ, 2, T_IMM, S_HOLD, S_HOLD, F_A, M_NONE, 0, 8'h77));
        lit(8'h99, S_HOLD);
        out(8'h8B, 8'h77, 0, 0, "R3");
        // R4: conditional and unconditional branches
        lit(8'h00, S_HOLD);
        put(mkw(JZ, 1, T_HOLD, S_HOLD, S_HOLD, F_A, M_NONE, p + 3, 0));
        lit(8'hEE, S_HOLD);
        lit(8'hEE, S_HOLD);
        out(8'h8C, 8'h00, 0, 0, "R4");
        lit(8'h01, S_HOLD);
        put(mkw(JZ, 1, T_HOLD, S_HOLD, S_HOLD, F_A, M_NONE, 250, 0));
        out(8'h8D, 8'h01, 0, 0, "R4");
        put(mkw(JNZ, 1, T_HOLD, S_HOLD, S_HOLD, F_A, M_NONE, p + 2, 0));
        lit(8'h00, S_HOLD);
        out(8'h8E, 8'h01, 0, 0, "R4");
        put(mkw(JMP, 1, T_HOLD, S_HOLD, S_HOLD, F_A, M_NONE, p + 2, 0));
        lit(8'h00, S_HOLD);
        out(8'h8F, 8'h01, 0, 0, "R4");
        // R5: nested call and return
        put(mkw(JMP, 1, T_HOLD, S_HOLD, S_PUSH, F_A, M_NONE, 200, 0));
        save = p;
        p = 200;
        put(mkw(JMP, 1, T_HOLD, S_HOLD, S_PUSH, F_A, M_NONE, 240, 0));
        out(8'h90, 8'h43, 0, 0, "R5");
        put(mkw(RET, 1, T_HOLD, S_HOLD, S_POP, F_A, M_NONE, 0, 0));
        p = 240;
        lit(8'h43, S_HOLD);
        put(mkw(RET, 1, T_HOLD, S_HOLD, S_POP, F_A, M_NONE, 0, 0));
        p = save;
        out(8'h91, 8'h43, 0, 0, "R5");
        // R8: RAM write and read back
        lit(8'h6D, S_HOLD);
        lit(8'h45, S_PUSH);
        put(mkw(SEQ, 1, T_DS, S_POP, S_HOLD, F_A, M_WR, 0, 0));
        lit(8'h00, S_HOLD);
        lit(8'h45, S_HOLD);
        put(mkw(SEQ, 1, T_MEM, S_HOLD, S_HOLD, F_A, M_RD, 0, 0));
        out(8'h92, 8'h6D, 0, 0, "R8");
        // R10: ROM read
        lit(8'h12, S_HOLD);
        put(mkw(SEQ, 1, T_MEM, S_HOLD, S_HOLD, F_A, M_RD, 0, 0));
        out(8'h93, 8'hB7, 0, 0, "R10");
        // R10: ROM write must not reach the RAM alias
        lit(8'h99, S_HOLD);
        lit(8'h05, S_PUSH);
        put(mkw(SEQ, 1, T_DS, S_POP, S_HOLD, F_A, M_WR, 0, 0));
        lit(8'h45, S_HOLD);
        put(mkw(SEQ, 1, T_MEM, S_HOLD, S_HOLD, F_A, M_RD, 0, 0));
        out(8'h94, 8'h6D, 0, 0, "R10");
        // R9: I/O read
        lit(8'hC3, S_HOLD);
        put(mkw(SEQ, 1, T_MEM, S_HOLD, S_HOLD, F_A, M_RD, 0, 0));
        out(8'h95, 8'h44, 0, 0, "R9");
        // R11: data stack underflow, then a clean push and pop
        put(mkw(SEQ, 1, T_HOLD, S_POP, S_HOLD, F_A, M_NONE, 0, 0));
        lit(8'h5E, S_PUSH);
        popw();
        out(8'h96, 8'h44, 1, 0, "R11");
        // R11: return stack overflow
        for (int k = 0; k < 5; k++) begin
            put(mkw(SEQ, 1, T_HOLD, S_HOLD, S_PUSH, F_A, M_NONE, 0, 0));
        end
        out(8'h97, 8'h44, 1, 1, "R11");
        // Idle word (all zero) holds the sequencer
        put('0);
    endtask

    initial begin
        logic [ADDR_W-1:0] hold_addr;
        assemble();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(int'(code_addr), 0, "R1");
        check(int'(tr_out), 0, "R1");
        check(int'(ds_err), 0, "R1");
        check(int'(rs_err), 0, "R1");
        rst = 1'b0;
        for (int c = 0; c < 2000 && exp_q.size() != 0; c++) begin
            @(negedge clk);
        end
        if (exp_q.size() != 0) begin
            check(exp_q.size(), 0, "R4");
        end
        repeat (2) @(negedge clk);
        hold_addr = code_addr;
        repeat (4) @(negedge clk);
        check(int'(code_addr), int'(hold_addr), "R3");
        check(int'(ds_err), 1, "R11");
        check(int'(rs_err), 1, "R11");
        check(int'(tr_out), 8'h44, "R11");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nvec++;
            nerr++;
            $display("FAIL R1: actual watchdog expired expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule